// File: doc/BRIEF.md
# Dual Cascadable 8-bit Interval Timer

This block holds two 8-bit up counters that share one binary prescaler. The prescaler advances once per system clock while its run input is high. It offers four count-enable taps that divide by 2, 8, 32 and 512. When its run input is low it is held at zero.

Counter 0 counts a prescaler tap or rising edges on an external pin. The pin is synchronised before use. Counter 1 counts a prescaler tap or counter 0's compare events. Each counter compares itself against its own 8-bit compare value. On a count enable where the value equals the compare value, the counter gives a one-cycle match pulse and reloads to zero. When the cascade input is high, the two counters form one 16-bit timer: counter 1 counts counter 0's carries, and the match needs all 16 bits to agree.

All logic runs on the one clock and uses single-cycle enables rather than derived clocks. Each counter has a small control state machine with two states. `CT_IDLE` holds the count at zero. `CT_COUNT` allows counting. The state machine takes the transition *arm* (CT_IDLE to CT_COUNT) on the first clock edge that sees the run input high. It takes the transition *disarm* (CT_COUNT to CT_IDLE) on the first edge that sees the run input low. Counting therefore starts one cycle after the run input rises.

Top module: `twin_tick_timer`

## Requirements
- R1: After reset both counts are 0, both counters are in CT_IDLE, and `match0_o`, `match1_o` and `ovf_o` are low.
- R2: While `pre_run_i` is 1, the prescaler taps give one-cycle enables every 2, 8, 32 and 512 clocks.
- R3: While `pre_run_i` is 0, the prescaler is held at zero and no tap enable occurs, so counters that select taps do not move.
- R4: `sel0_i` picks counter 0's enable: 00 = external pin, 01 = divide-by-2 tap, 10 = divide-by-8 tap, 11 = divide-by-32 tap.
- R5: With `cascade_i` = 0, `sel1_i` picks counter 1's enable: 00 = counter 0 compare event, 01 = divide-by-2 tap, 10 = divide-by-32 tap, 11 = divide-by-512 tap.
- R6: With `cascade_i` = 0, a counter that equals its compare value on a count enable reloads to 0, and its match output is high for exactly the next cycle. The match period is (compare + 1) times the period of the selected enable.
- R7: A run input of 0 clears that counter to 0 on the next edge and holds it there.
- R8: The external pin passes through two synchroniser flops. Each rising edge of the pin advances counter 0 by exactly one, however long the pin stays high.
- R9: With `cascade_i` = 1, counter 1 advances only when counter 0 wraps from 255 to 0. A match needs {count1, count0} to equal {cmp1_i, cmp0_i}. The match clears both counters and pulses `match1_o`. `match0_o` stays low.
- R10: `ovf_o` is high for one cycle after either counter wraps from 255 to 0 on a count enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_cnt_i | input | 1 | External count pin (asynchronous) |
| pre_run_i | input | 1 | Prescaler run control |
| run0_i | input | 1 | Counter 0 run control |
| run1_i | input | 1 | Counter 1 run control |
| sel0_i | input | 2 | Counter 0 enable select |
| sel1_i | input | 2 | Counter 1 enable select (non-cascade) |
| cascade_i | input | 1 | 1 = single 16-bit timer |
| cmp0_i | input | 8 | Counter 0 compare value |
| cmp1_i | input | 8 | Counter 1 compare value |
| count0_o | output | 8 | Counter 0 value |
| count1_o | output | 8 | Counter 1 value |
| match0_o | output | 1 | Counter 0 match pulse |
| match1_o | output | 1 | Counter 1 (or 16-bit) match pulse |
| ovf_o | output | 1 | Wrap pulse |

## Verification
The main function is measured as the cycle distance between consecutive match pulses. This is done for every value of each select input and for compare values 0, 1, 2, 3, 4 and 9. A wrong tap, a swapped select code or an off-by-one reload each gives a period different from the expected (compare + 1) times the tap period.

The cascade pattern uses a 16-bit compare of 0x0102. Only a true 16-bit carry chain gives 518 cycles with exactly one wrap pulse and no counter 0 match.

Pin pulses of three cycles and a long high level separate edge counting from level counting. Idle periods with the prescaler halted and the run input dropped show that holding and clearing work.

// File: rtl/ttm_pkg.sv
`timescale 1ns/1ps
package ttm_pkg;
    localparam int CNT_W_DEF = 8;
    localparam int N_TAPS_DEF = 4;

    typedef enum logic {
        CT_IDLE  = 1'b0,
        CT_COUNT = 1'b1
    } ctr_state_e;

    // counter 0 enable source codes
    localparam logic [1:0] SEL0_PIN = 2'b00;
    localparam logic [1:0] SEL0_D2  = 2'b01;
    localparam logic [1:0] SEL0_D8  = 2'b10;
    localparam logic [1:0] SEL0_D32 = 2'b11;

    // counter 1 enable source codes (non-cascade)
    localparam logic [1:0] SEL1_HIT  = 2'b00;
    localparam logic [1:0] SEL1_D2   = 2'b01;
    localparam logic [1:0] SEL1_D32  = 2'b10;
    localparam logic [1:0] SEL1_D512 = 2'b11;

    // low prescaler bits that must all be one for tap i to fire
    function automatic int tap_bits(input int i);
        case (i)
            0:       return 1;
            1:       return 3;
            2:       return 5;
            default: return 9;
        endcase
    endfunction
endpackage

// File: rtl/ttm_prescaler.sv
`timescale 1ns/1ps
module ttm_prescaler
    import ttm_pkg::*;
#(
    parameter int N_TAPS = N_TAPS_DEF
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    output logic [N_TAPS-1:0] tap_o
);
    localparam int PRE_W = tap_bits(N_TAPS - 1);

    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pre_q <= '0;
        end else if (!run_i) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
        localparam int TB = tap_bits(g);
        assign tap_o[g] = run_i && (&pre_q[TB-1:0]);
    end

    // R3
    halt_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (pre_q == '0));

    // R2
    fast_tap_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tap_o[0] |=> !tap_o[0]);
endmodule

// File: rtl/ttm_pin_sync.sv
`timescale 1ns/1ps
module ttm_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic rise_o
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[STAGES-1:0], pin_i};
        end
    end

    assign rise_o = sh_q[STAGES-1] && !sh_q[STAGES];

    // R8
    rise_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);
endmodule

// File: rtl/ttm_counter.sv
`timescale 1ns/1ps
module ttm_counter
    import ttm_pkg::*;
#(
    parameter int W = CNT_W_DEF
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         run_i,
    input  logic         tick_i,
    input  logic         self_match_i,
    input  logic         clr_i,
    input  logic [W-1:0] cmp_i,
    output logic [W-1:0] cnt_o,
    output logic         hit_o,
    output logic         wrap_o
);
    ctr_state_e state_q, state_d;
    logic advance, at_cmp, self_hit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CT_IDLE:  if (run_i)  state_d = CT_COUNT;
            CT_COUNT: if (!run_i) state_d = CT_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= CT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign advance  = (state_q == CT_COUNT) && run_i && tick_i;
    assign at_cmp   = (cnt_o == cmp_i);
    assign self_hit = advance && self_match_i && at_cmp;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_o <= '0;
        end else begin
            unique case (state_q)
                CT_IDLE: cnt_o <= '0;
                CT_COUNT: begin
                    if (!run_i || clr_i) begin
                        cnt_o <= '0;
                    end else if (advance) begin
                        cnt_o <= self_hit ? '0 : cnt_o + 1'b1;
                    end
                end
            endcase
        end
    end

    assign hit_o  = advance && at_cmp;
    assign wrap_o = advance && !clr_i && !self_hit && (&cnt_o);

    // R7
    run_low_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (cnt_o == '0));

    // R7
    idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == CT_IDLE) |-> (cnt_o == '0));

    // R6
    step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (advance && !clr_i && !self_hit) |=> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/twin_tick_timer.sv
`timescale 1ns/1ps
module twin_tick_timer
    import ttm_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ext_cnt_i,
    input  logic             pre_run_i,
    input  logic             run0_i,
    input  logic             run1_i,
    input  logic [1:0]       sel0_i,
    input  logic [1:0]       sel1_i,
    input  logic             cascade_i,
    input  logic [CNT_W-1:0] cmp0_i,
    input  logic [CNT_W-1:0] cmp1_i,
    output logic [CNT_W-1:0] count0_o,
    output logic [CNT_W-1:0] count1_o,
    output logic             match0_o,
    output logic             match1_o,
    output logic             ovf_o
);
    localparam int N_TAPS = N_TAPS_DEF;

    logic [N_TAPS-1:0] tap;
    logic pin_rise;
    logic tick0, tick1;
    logic hit0, hit1, wrap0, wrap1;
    logic joint;

    ttm_prescaler #(.N_TAPS(N_TAPS)) u_pre (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .run_i (pre_run_i),
        .tap_o (tap)
    );

    ttm_pin_sync #(.STAGES(SYNC_STAGES)) u_pin (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .pin_i (ext_cnt_i),
        .rise_o(pin_rise)
    );

    always_comb begin
        tick0 = 1'b0;
        unique case (sel0_i)
            SEL0_PIN: tick0 = pin_rise;
            SEL0_D2:  tick0 = tap[0];
            SEL0_D8:  tick0 = tap[1];
            SEL0_D32: tick0 = tap[2];
        endcase
    end

    always_comb begin
        tick1 = 1'b0;
        if (cascade_i) begin
            tick1 = wrap0;
        end else begin
            unique case (sel1_i)
                SEL1_HIT:  tick1 = hit0;
                SEL1_D2:   tick1 = tap[0];
                SEL1_D32:  tick1 = tap[2];
                SEL1_D512: tick1 = tap[3];
            endcase
        end
    end

    assign joint = cascade_i && hit0 && run1_i && (count1_o == cmp1_i);

    ttm_counter #(.W(CNT_W)) u_c0 (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .run_i       (run0_i),
        .tick_i      (tick0),
        .self_match_i(!cascade_i),
        .clr_i       (joint),
        .cmp_i       (cmp0_i),
        .cnt_o       (count0_o),
        .hit_o       (hit0),
        .wrap_o      (wrap0)
    );

    ttm_counter #(.W(CNT_W)) u_c1 (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .run_i       (run1_i),
        .tick_i      (tick1),
        .self_match_i(!cascade_i),
        .clr_i       (joint),
        .cmp_i       (cmp1_i),
        .cnt_o       (count1_o),
        .hit_o       (hit1),
        .wrap_o      (wrap1)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            match0_o <= 1'b0;
            match1_o <= 1'b0;
            ovf_o    <= 1'b0;
        end else begin
            match0_o <= !cascade_i && hit0;
            match1_o <= cascade_i ? joint : hit1;
            ovf_o    <= wrap0 || wrap1;
        end
    end

    // R6
    match0_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cascade_i && hit0) |=> (match0_o && count0_o == '0));

    // R9
    cascade_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cascade_i && $past(cascade_i)) |-> !match0_o);

    // R9
    joint_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        joint |=> (match1_o && count0_o == '0 && count1_o == '0));

    // R10
    ovf_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_o |-> (count0_o == '0 || count1_o == '0));
endmodule

// File: tb/twin_tick_timer_tb_top.sv
`timescale 1ns/1ps
module twin_tick_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin = 1'b0;
    logic       pre_run = 1'b0;
    logic       run0 = 1'b0;
    logic       run1 = 1'b0;
    logic [1:0] sel0 = 2'b00;
    logic [1:0] sel1 = 2'b00;
    logic       casc = 1'b0;
    logic [7:0] cmp0 = 8'hFF;
    logic [7:0] cmp1 = 8'hFF;
    logic [7:0] count0, count1;
    logic       match0, match1, ovf;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    twin_tick_timer dut_i (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .ext_cnt_i(pin),
        .pre_run_i(pre_run),
        .run0_i   (run0),
        .run1_i   (run1),
        .sel0_i   (sel0),
        .sel1_i   (sel1),
        .cascade_i(casc),
        .cmp0_i   (cmp0),
        .cmp1_i   (cmp1),
        .count0_o (count0),
        .count1_o (count1),
        .match0_o (match0),
        .match1_o (match1),
        .ovf_o    (ovf)
    );

    typedef struct packed {
        logic       casc;
        logic [1:0] s0;
        logic [7:0] c0;
        logic [1:0] s1;
        logic [7:0] c1;
        logic       watch;
        logic [15:0] per;
        logic [1:0] kind; // 0: R4, 1: R5, 2: R9
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd1, 8'd3, 2'd1, 8'hFF, 1'b0, 16'd8,   2'd0},
        '{1'b0, 2'd2, 8'd1, 2'd1, 8'hFF, 1'b0, 16'd16,  2'd0},
        '{1'b0, 2'd3, 8'd0, 2'd1, 8'hFF, 1'b0, 16'd32,  2'd0},
        '{1'b0, 2'd1, 8'd9, 2'd1, 8'hFF, 1'b0, 16'd20,  2'd0},
        '{1'b0, 2'd1, 8'd0, 2'd1, 8'd4,  1'b1, 16'd10,  2'd1},
        '{1'b0, 2'd1, 8'd0, 2'd2, 8'd1,  1'b1, 16'd64,  2'd1},
        '{1'b0, 2'd1, 8'd0, 2'd3, 8'd0,  1'b1, 16'd512, 2'd1},
        '{1'b0, 2'd1, 8'd1, 2'd0, 8'd2,  1'b1, 16'd12,  2'd1},
        '{1'b1, 2'd1, 8'd2, 2'd0, 8'd1,  1'b1, 16'd518, 2'd2}
    };

    function automatic string kind_tag(input logic [1:0] k);
        case (k)
            2'd0:    return "R4";
            2'd1:    return "R5";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_all();
        pre_run = 1'b0;
        run0 = 1'b0;
        run1 = 1'b0;
        casc = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_pulse(input bit w, input int limit,
                              output int n, output int m0s, output int ovfs);
        n = 0;
        m0s = 0;
        ovfs = 0;
        do begin
            @(negedge clk);
            n++;
            m0s += int'(match0);
            ovfs += int'(ovf);
        end while (!(w ? match1 : match0) && n < limit);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(count0 == 8'd0, "R1 count0 after reset", count0, 0);
        chk(count1 == 8'd0, "R1 count1 after reset", count1, 0);
        chk(!match0, "R1 match0 after reset", match0, 0);
        chk(!match1, "R1 match1 after reset", match1, 0);
        chk(!ovf, "R1 ovf after reset", ovf, 0);

        // vector table: match period per select, compare and mode
        for (int i = 0; i < NV; i++) begin
            int n, a, b;
            bit pulse;
            idle_all();
            sel0 = VECS[i].s0;
            cmp0 = VECS[i].c0;
            sel1 = VECS[i].s1;
            cmp1 = VECS[i].c1;
            casc = VECS[i].casc;
            pre_run = 1'b1;
            run0 = 1'b1;
            run1 = 1'b1;
            wait_pulse(VECS[i].watch, 3000, n, a, b);
            pulse = VECS[i].watch ? match1 : match0;
            chk(pulse, {kind_tag(VECS[i].kind), " R6 first match seen"}, int'(pulse), 1);
            if (VECS[i].watch) begin
                chk(count1 == 8'd0, "R6 count1 reloaded at match", count1, 0);
            end else begin
                chk(count0 == 8'd0, "R6 count0 reloaded at match", count0, 0);
            end
            wait_pulse(VECS[i].watch, 3000, n, a, b);
            chk(n == int'(VECS[i].per),
                {kind_tag(VECS[i].kind), " R2 R6 match period"}, n, int'(VECS[i].per));
            if (VECS[i].casc) begin
                chk(a == 0, "R9 match0 silent in cascade", a, 0);
                chk(b == 1, "R10 one carry wrap per 16-bit period", b, 1);
            end else begin
                chk(b == 0, "R10 no wrap when compare is reached", b, 0);
            end
        end

        // R3 prescaler halted: tap-driven counters stay put
        idle_all();
        sel0 = 2'd1;
        sel1 = 2'd1;
        cmp0 = 8'hFF;
        cmp1 = 8'hFF;
        run0 = 1'b1;
        run1 = 1'b1;
        repeat (40) @(negedge clk);
        chk(count0 == 8'd0, "R3 count0 frozen with prescaler halted", count0, 0);
        chk(count1 == 8'd0, "R3 count1 frozen with prescaler halted", count1, 0);

        // R7 run bit clears
        pre_run = 1'b1;
        repeat (30) @(negedge clk);
        chk(count0 != 8'd0, "R7 count0 advanced before clear", count0, 1);
        run0 = 1'b0;
        @(negedge clk);
        chk(count0 == 8'd0, "R7 count0 cleared on run low", count0, 0);
        repeat (10) @(negedge clk);
        chk(count0 == 8'd0, "R7 count0 held at zero", count0, 0);

        // R8 external pin edges
        idle_all();
        sel0 = 2'd0;
        cmp0 = 8'hFF;
        run0 = 1'b1;
        repeat (3) @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            pin = 1'b1;
            repeat (3) @(negedge clk);
            pin = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        chk(count0 == 8'd5, "R8 R4 five pin edges counted", count0, 5);
        pin = 1'b1;
        repeat (20) @(negedge clk);
        chk(count0 == 8'd6, "R8 long high level counts once", count0, 6);
        pin = 1'b0;

        // R10 cascade carry into counter 1
        begin
            int n;
            idle_all();
            casc = 1'b1;
            sel0 = 2'd1;
            cmp0 = 8'hFF;
            cmp1 = 8'hFF;
            pre_run = 1'b1;
            run0 = 1'b1;
            run1 = 1'b1;
            n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (!ovf && n < 700);
            chk(ovf, "R10 wrap pulse seen", int'(ovf), 1);
            chk(count0 == 8'd0, "R10 count0 zero at wrap", count0, 0);
            chk(count1 == 8'd1, "R9 count1 took the carry", count1, 1);
            @(negedge clk);
            chk(!ovf, "R10 wrap pulse lasts one cycle", int'(ovf), 0);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog run incomplete actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule